// File: doc/BRIEF.md
# Watchdog Reset Sequencer

This block sits between a watchdog counter and the clock and reset network of a small microcontroller core. When the watchdog reports an overflow, it runs a fixed reset sequence. First it asserts the internal reset, which also clears the watchdog itself. It keeps the ordinary port pins in high impedance and pulls a dedicated reset-indicator pin low. If a crystal or ceramic resonator is the clock source, it also stops the oscillator. After the reset period, a crystal source gets a selectable power-of-two stabilization wait. Next, with either clock source, the CPU clock stays off for a fixed stall while the configuration option byte is read. A single release cycle then hands the clock back to the CPU for normal reset processing.

With the high-speed internal clock or an external clock input, the oscillator runs through the whole sequence and the stabilization wait is skipped. A new overflow at any point of the sequence starts it again from the beginning. Power-on reset puts the block straight into the reset phase. The indicator pin stays low after the sequence ends, until software drives it high.

Top module: `wdt_reset_seq`

## Requirements
- R1: An overflow sampled high while the CPU is running (cpuClkEn=1, portHiZ=0) makes intRst=1, wdtClr=1 and cpuClkEn=0 from the next cycle.
- R2: The reset phase (intRst=1) lasts exactly RST_CYCLES clock cycles, even when the overflow is a single-cycle pulse.
- R3: portHiZ is 1 in every cycle of the sequence, including the release cycle, and is 0 only while the CPU runs normally.
- R4: indPin is 0 while intRst=1 and stays 0 after the sequence ends. It goes to 1 one cycle after swIndHigh is sampled high during normal running. swIndHigh sampled at any other time has no effect.
- R5: With xtalSel=1, oscEn is 0 throughout the reset phase. It is followed by a stabilization phase of 2^(STAB_MIN_LOG2+stabSel) cycles with oscEn=1, intRst=0 and cpuClkEn=0. xtalSel and stabSel are taken as sampled in the last reset cycle.
- R6: With xtalSel=0, oscEn stays 1 throughout, and the option-read phase follows the reset phase directly.
- R7: The option-read phase lasts OPT_CYCLES cycles with cpuClkEn=0 and intRst=0. It is followed by exactly one release cycle with cpuClkEn=1 and portHiZ=1, and then by normal running.
- R8: An overflow sampled in any phase of the sequence restarts the reset phase from its first cycle, with its full length.
- R9: While rstPorN=0, the block is in the reset phase: intRst=1, wdtClr=1, indPin=0, portHiZ=1 and cpuClkEn=0. The full sequence runs after rstPorN is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rstPorN | input | 1 | Asynchronous power-on reset, active low |
| wdtOvf | input | 1 | Watchdog overflow pulse |
| xtalSel | input | 1 | 1 = crystal/ceramic source, 0 = internal or external clock |
| stabSel | input | SEL_W | Stabilization wait exponent offset |
| swIndHigh | input | 1 | Software write of a high level to the indicator pin |
| intRst | output | 1 | Internal reset to the core |
| wdtClr | output | 1 | Clear to the watchdog counter |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock gate enable |
| portHiZ | output | 1 | Tri-state control for ordinary port pins |
| indPin | output | 1 | Reset-indicator pin level |

## Verification
The bench builds the block with RST_CYCLES=5, OPT_CYCLES=7 and STAB_MIN_LOG2=2, and leaves SEL_W at 3. With these values every stabilization length from 4 to 512 cycles, including both extremes of stabSel, fits in a short run. This lets each random sequence be followed cycle by cycle. Because the phases are short, restarts can be aimed at the last cycle of each phase, and a change to stabSel after it has been latched can be shown to have no effect.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_RESET    = 3'd1,
    ST_OSC_STAB = 3'd2,
    ST_OPT_READ = 3'd3,
    ST_RELEASE  = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;    // restart the phase counter
    logic cfgLatch;  // capture stabilization select
    logic indClr;    // force indicator level low
    logic indSet;    // allow software write of indicator level
  } dpCtl_t;

endpackage

// File: rtl/wrs_datapath.sv
module wrs_datapath
  import wrs_pkg::*;
#(
  parameter int RST_CYCLES    = 16,
  parameter int OPT_CYCLES    = 1024,
  parameter int STAB_MIN_LOG2 = 10,
  parameter int SEL_W         = 3
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  dpCtl_t           ctl,
  input  logic [SEL_W-1:0] stabSel,
  input  logic             swIndHigh,
  output logic             rstDone,
  output logic             stabDone,
  output logic             optDone,
  output logic             indLevel
);

  localparam int STAB_MAX = 1 << (STAB_MIN_LOG2 + (1 << SEL_W) - 1);
  localparam int FIX_MAX  = (RST_CYCLES > OPT_CYCLES) ? RST_CYCLES : OPT_CYCLES;
  localparam int CNT_MAX  = (STAB_MAX > FIX_MAX) ? STAB_MAX : FIX_MAX;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] phaseCnt;
  logic [SEL_W-1:0] selQ;
  logic [CNT_W-1:0] stabLast;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)        phaseCnt <= '0;
    else if (ctl.cntClr) phaseCnt <= '0;
    else                 phaseCnt <= phaseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)          selQ <= '0;
    else if (ctl.cfgLatch) selQ <= stabSel;
  end

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)                      indLevel <= 1'b0;
    else if (ctl.indClr)               indLevel <= 1'b0;
    else if (ctl.indSet && swIndHigh)  indLevel <= 1'b1;
  end

  assign stabLast = CNT_W'((64'(1) << (STAB_MIN_LOG2 + int'(selQ))) - 64'(1));

  assign rstDone  = (phaseCnt == CNT_W'(RST_CYCLES - 1));
  assign stabDone = (phaseCnt == stabLast);
  assign optDone  = (phaseCnt == CNT_W'(OPT_CYCLES - 1));

endmodule

// File: rtl/wrs_ctrl.sv
module wrs_ctrl
  import wrs_pkg::*;
(
  input  logic   clk,
  input  logic   rstPorN,
  input  logic   wdtOvf,
  input  logic   xtalSel,
  input  logic   rstDone,
  input  logic   stabDone,
  input  logic   optDone,
  output dpCtl_t ctl,
  output logic   intRst,
  output logic   wdtClr,
  output logic   oscEn,
  output logic   cpuClkEn,
  output logic   portHiZ
);

  seqState_t state, nextState;
  logic      restart;

  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) state <= ST_RESET;
    else          state <= nextState;
  end

  assign restart = wdtOvf && (state != ST_RUN);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN:      if (wdtOvf)   nextState = ST_RESET;
      ST_RESET:    if (rstDone)  nextState = xtalSel ? ST_OSC_STAB : ST_OPT_READ;
      ST_OSC_STAB: if (stabDone) nextState = ST_OPT_READ;
      ST_OPT_READ: if (optDone)  nextState = ST_RELEASE;
      ST_RELEASE:                nextState = ST_RUN;
      default:                   nextState = ST_RESET;
    endcase
    if (restart) nextState = ST_RESET;
  end

  always_comb begin
    ctl.cntClr   = restart || (nextState != state) || (state == ST_RUN);
    ctl.cfgLatch = (state == ST_RESET);
    ctl.indClr   = (state == ST_RESET);
    ctl.indSet   = (state == ST_RUN);
  end

  always_comb begin
    intRst   = (state == ST_RESET);
    wdtClr   = (state == ST_RESET);
    oscEn    = !((state == ST_RESET) && xtalSel);
    cpuClkEn = (state == ST_RUN) || (state == ST_RELEASE);
    portHiZ  = (state != ST_RUN);
  end

endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq
  import wrs_pkg::*;
#(
  parameter int RST_CYCLES    = 16,
  parameter int OPT_CYCLES    = 1024,
  parameter int STAB_MIN_LOG2 = 10,
  parameter int SEL_W         = 3
) (
  input  logic             clk,
  input  logic             rstPorN,
  input  logic             wdtOvf,
  input  logic             xtalSel,
  input  logic [SEL_W-1:0] stabSel,
  input  logic             swIndHigh,
  output logic             intRst,
  output logic             wdtClr,
  output logic             oscEn,
  output logic             cpuClkEn,
  output logic             portHiZ,
  output logic             indPin
);

  dpCtl_t ctl;
  logic   rstDone, stabDone, optDone, indLevel;

  wrs_ctrl u_ctrl (
    .clk      (clk),
    .rstPorN  (rstPorN),
    .wdtOvf   (wdtOvf),
    .xtalSel  (xtalSel),
    .rstDone  (rstDone),
    .stabDone (stabDone),
    .optDone  (optDone),
    .ctl      (ctl),
    .intRst   (intRst),
    .wdtClr   (wdtClr),
    .oscEn    (oscEn),
    .cpuClkEn (cpuClkEn),
    .portHiZ  (portHiZ)
  );

  wrs_datapath #(
    .RST_CYCLES    (RST_CYCLES),
    .OPT_CYCLES    (OPT_CYCLES),
    .STAB_MIN_LOG2 (STAB_MIN_LOG2),
    .SEL_W         (SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstPorN   (rstPorN),
    .ctl       (ctl),
    .stabSel   (stabSel),
    .swIndHigh (swIndHigh),
    .rstDone   (rstDone),
    .stabDone  (stabDone),
    .optDone   (optDone),
    .indLevel  (indLevel)
  );

  assign indPin = indLevel && !intRst;

endmodule

// File: rtl/wrs_checker.sv
module wrs_checker #(
  parameter int RST_CYCLES = 16
) (
  input logic clk,
  input logic rstPorN,
  input logic wdtOvf,
  input logic xtalSel,
  input logic intRst,
  input logic wdtClr,
  input logic oscEn,
  input logic cpuClkEn,
  input logic portHiZ,
  input logic indPin
);

  // length of the current reset phase, counted independently of the design
  logic [15:0] rstLen;
  always_ff @(posedge clk or negedge rstPorN) begin
    if (!rstPorN)    rstLen <= 16'd1;
    else if (wdtOvf) rstLen <= 16'd1;
    else if (intRst) rstLen <= rstLen + 16'd1;
    else             rstLen <= 16'd0;
  end

  // R1 and R8: any overflow puts the block in reset next cycle
  a_r1_ovf_enters_reset: assert property (@(posedge clk) disable iff (!rstPorN)
    wdtOvf |=> (intRst && wdtClr && !cpuClkEn));

  a_r2_reset_length: assert property (@(posedge clk) disable iff (!rstPorN)
    $fell(intRst) |-> (rstLen == 16'(RST_CYCLES + 1)));

  a_r3_ports_hiz: assert property (@(posedge clk) disable iff (!rstPorN)
    (intRst || !cpuClkEn) |-> portHiZ);

  a_r4_ind_low: assert property (@(posedge clk) disable iff (!rstPorN)
    intRst |-> !indPin);

  a_r5_osc_stopped: assert property (@(posedge clk) disable iff (!rstPorN)
    (intRst && xtalSel) |-> !oscEn);

  a_r6_osc_running: assert property (@(posedge clk) disable iff (!rstPorN)
    !xtalSel |-> oscEn);

  a_r7_release_single: assert property (@(posedge clk) disable iff (!rstPorN)
    (cpuClkEn && portHiZ && !wdtOvf) |=> (cpuClkEn && !portHiZ));

  a_r7_release_first: assert property (@(posedge clk) disable iff (!rstPorN)
    $rose(cpuClkEn) |-> portHiZ);

endmodule

bind wdt_reset_seq wrs_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk      (clk),
  .rstPorN  (rstPorN),
  .wdtOvf   (wdtOvf),
  .xtalSel  (xtalSel),
  .intRst   (intRst),
  .wdtClr   (wdtClr),
  .oscEn    (oscEn),
  .cpuClkEn (cpuClkEn),
  .portHiZ  (portHiZ),
  .indPin   (indPin)
);

// File: tb/wdt_reset_seq_tb.sv
module wdt_reset_seq_tb;

  localparam int TB_RST = 5;
  localparam int TB_OPT = 7;
  localparam int TB_L   = 2;
  localparam int TB_SW  = 3;

  localparam int PH_RUN = 0, PH_RST = 1, PH_STAB = 2, PH_OPT = 3, PH_REL = 4;

  logic clk = 1'b0;
  logic rstPorN = 1'b0;
  logic wdtOvf = 1'b0;
  logic xtalSel = 1'b0;
  logic [TB_SW-1:0] stabSel = '0;
  logic swIndHigh = 1'b0;
  logic intRst, wdtClr, oscEn, cpuClkEn, portHiZ, indPin;

  int checks = 0;
  int fails = 0;
  bit expInd = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wdt_reset_seq #(
    .RST_CYCLES    (TB_RST),
    .OPT_CYCLES    (TB_OPT),
    .STAB_MIN_LOG2 (TB_L),
    .SEL_W         (TB_SW)
  ) u_dut (
    .clk(clk), .rstPorN(rstPorN), .wdtOvf(wdtOvf), .xtalSel(xtalSel),
    .stabSel(stabSel), .swIndHigh(swIndHigh), .intRst(intRst), .wdtClr(wdtClr),
    .oscEn(oscEn), .cpuClkEn(cpuClkEn), .portHiZ(portHiZ), .indPin(indPin)
  );

  function automatic int stabLen(int sel);
    return 1 << (TB_L + sel);
  endfunction

  function automatic int seqTotal(bit x, int sel);
    return TB_RST + (x ? stabLen(sel) : 0) + TB_OPT + 1;
  endfunction

  function automatic int phaseAt(int i, bit x, int sel);
    int rel;
    if (i < TB_RST) return PH_RST;
    rel = i - TB_RST;
    if (x) begin
      if (rel < stabLen(sel)) return PH_STAB;
      rel = rel - stabLen(sel);
    end
    if (rel < TB_OPT) return PH_OPT;
    if (rel == TB_OPT) return PH_REL;
    return PH_RUN;
  endfunction

  // {intRst, wdtClr, oscEn, cpuClkEn, portHiZ, indPin}
  function automatic logic [5:0] expVec(int ph, bit x, bit ind);
    case (ph)
      PH_RST:  return {1'b1, 1'b1, !x, 1'b0, 1'b1, 1'b0};
      PH_STAB: return 6'b001010;
      PH_OPT:  return 6'b001010;
      PH_REL:  return 6'b001110;
      default: return {5'b00110, ind};
    endcase
  endfunction

  function automatic string phaseTag(int ph, bit x);
    if (!x && ph != PH_RUN) return "R6";
    case (ph)
      PH_RST:  return "R2";
      PH_STAB: return "R5";
      PH_OPT:  return "R7";
      PH_REL:  return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic checkVec(input logic [5:0] exp, input string tag);
    logic [5:0] act;
    act = {intRst, wdtClr, oscEn, cpuClkEn, portHiZ, indPin};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // called at a negedge that is offset 0 of a sequence
  task automatic followSeq(input bit x, input int sel, input int restartAt,
                           input int swAt, input bit scramble, input string tag0);
    int i;
    bit restarted;
    string tag;
    i = 0;
    tag = tag0;
    expInd = 1'b0;
    while (i < seqTotal(x, sel)) begin
      checkVec(expVec(phaseAt(i, x, sel), x, expInd),
               (i == 0) ? tag : phaseTag(phaseAt(i, x, sel), x));
      restarted = 1'b0;
      if (i == swAt) swIndHigh = 1'b1;          // R4: ignored outside running
      if (i == restartAt) begin
        wdtOvf = 1'b1;
        restartAt = -1;
        restarted = 1'b1;
      end
      @(negedge clk);
      wdtOvf = 1'b0;
      swIndHigh = 1'b0;
      if (restarted) begin
        i = 0;
        tag = "R8";
        stabSel = TB_SW'(sel);
      end else begin
        i++;
        if (scramble && i == TB_RST) stabSel = TB_SW'($urandom);  // R5 latch
      end
    end
    checkVec(expVec(PH_RUN, x, 1'b0), "R4");
  endtask

  task automatic startSeq(input bit x, input int sel, input int restartAt,
                          input int swAt, input bit scramble);
    xtalSel = x;
    stabSel = TB_SW'(sel);
    wdtOvf = 1'b1;
    @(negedge clk);
    wdtOvf = 1'b0;
    followSeq(x, sel, restartAt, swAt, scramble, "R1");
  endtask

  task automatic swWrite();
    swIndHigh = 1'b1;
    @(negedge clk);
    swIndHigh = 1'b0;
    expInd = 1'b1;
    checkVec(expVec(PH_RUN, xtalSel, expInd), "R4");
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    // R9: power-on reset state
    xtalSel = 1'b1;
    stabSel = 3'd1;
    repeat (3) @(negedge clk);
    checkVec(expVec(PH_RST, 1'b1, 1'b0), "R9");
    xtalSel = 1'b0;
    @(negedge clk);
    checkVec(expVec(PH_RST, 1'b0, 1'b0), "R9");
    rstPorN = 1'b1;
    followSeq(1'b0, 0, -1, -1, 1'b0, "R9");
    @(negedge clk);

    // directed corners
    startSeq(1'b1, 0, -1, -1, 1'b0);                    // R5 shortest wait
    startSeq(1'b1, 7, -1, -1, 1'b0);                    // R5 longest wait
    startSeq(1'b0, 3, -1, -1, 1'b0);                    // R6 no wait
    startSeq(1'b1, 2, TB_RST - 1, -1, 1'b0);            // R8 last reset cycle
    startSeq(1'b1, 1, TB_RST + 3, -1, 1'b0);            // R8 in stabilization
    startSeq(1'b0, 0, TB_RST + TB_OPT - 1, -1, 1'b0);   // R8 last option cycle
    startSeq(1'b0, 0, TB_RST + TB_OPT, -1, 1'b0);       // R8 release cycle
    startSeq(1'b1, 3, -1, TB_RST + 2, 1'b1);            // R4 write ignored, R5 latch
    startSeq(1'b0, 0, -1, TB_RST + TB_OPT, 1'b0);       // R4 ignored in release
    swWrite();                                          // R4 write in running
    @(negedge clk);
    checkVec(expVec(PH_RUN, 1'b0, 1'b1), "R4");
    startSeq(1'b1, 0, -1, -1, 1'b0);                    // R4 indicator pulled low

    // constrained random sequences
    for (int n = 0; n < 30; n++) begin
      bit x;
      int sel, rs, sw;
      x   = 1'($urandom);
      sel = int'($urandom % 6);
      rs  = ($urandom % 4 == 0) ? int'($urandom % seqTotal(x, sel)) : -1;
      sw  = ($urandom % 3 == 0) ? int'($urandom % seqTotal(x, sel)) : -1;
      repeat (int'($urandom % 4)) @(negedge clk);
      if ($urandom % 2 == 0) swWrite();
      startSeq(x, sel, rs, sw, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule